// File: doc/BRIEF.md
# Image Sensor Bring-Up Sequencer

This block brings an image sensor out of reset without any processor help. It sits on the host side of a register-mapped bridge that carries accesses to the sensor's serial control bus. The block talks to the bridge through a simple request/acknowledge port. A single-cycle `start` pulse launches the whole routine. First the bridge is enabled and pointed at the sensor's slave address. Next a soft reset is issued and a settling delay is waited out. The sensor's maker code is then checked and its product code captured. Last, an initialisation table is streamed from an internal ROM, and a second settling delay precedes the final status.

Each sensor access is split into several bridge register accesses. The last of these is a status poll, and the number of polls has a fixed upper bound. Any failed access ends the routine at once, as does a maker code that does not match. The block then raises `error` and stays quiet until the next `start`. A clean run ends with `done` high and the 16-bit product code on `product_id`.

Top module: `sensor_bringup_seq`

## Requirements
- R1: After reset, `done`, `error` and `bus_req` are 0 and `product_id` is 0.
- R2: A run begins with two bridge writes, in this order: 0x1e to bridge offset 0x02, then 0x60 to bridge offset 0x03.
- R3: A sensor write of register r with value v is carried out in this order. First r is written to bridge offset 0x04 and v to offset 0x05. Next opcode 0x05 is written to offset 0x00. Then offset 0x01 is polled, and the expected completion code is 0x04.
- R4: A sensor read of register r is carried out in this order. First r is written to bridge offset 0x08. Next opcode 0x70 is written to offset 0x00. Offset 0x01 is then polled, and the expected completion code is 0x01. Last, the data is read from offset 0x09.
- R5: Status is read again only while it returns 0, and at most MAX_POLLS times per access. If the final status is not the expected code, `error` rises in the cycle after the acknowledging edge, and no further request is made.
- R6: After R2, the sensor gets a write of 0x80 to register 0x12. The next request is made DELAY_CYCLES+1 edges after the last status acknowledge of that write.
- R7: Sensor registers 0x1c and 0x1d are read next. If they do not return 0x7f and 0xa2, the run ends in `error` right after the second read, and no product read follows.
- R8: Sensor registers 0x0a and 0x0b are then read, and `product_id` becomes {reg 0x0a, reg 0x0b}.
- R9: Table entry i (i = 0 .. TABLE_LEN-1) is written in order. For i = 2 the entry is register 0xff with value 0x11. For every other i it is register 0x30+i with value 0xa0 XOR i. Entry TABLE_LEN is 0xff/0xff; it ends the stream and is not sent. A 0xff register alone does not end the stream.
- R10: `done` rises DELAY_CYCLES+1 edges after the last table access is acknowledged.
- R11: `done` and `error` hold until a `start` is accepted. A `start` is accepted only when the block is idle, done or in error, and clears both flags at the next edge. A `start` during a run is ignored.
- R12: `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay stable from a request until the edge where `bus_ack` is sampled high. One access completes per acknowledged cycle, and `bus_rdata` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle launch pulse |
| bus_req | output | 1 | Bridge access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Bridge register offset |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access completes in this cycle |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| done | output | 1 | Bring-up finished cleanly |
| error | output | 1 | Bring-up aborted |
| product_id | output | 16 | Captured product code |

## Verification
Timing is checked in two places: after the reset write and at the end of the table. In both, the result is due DELAY_CYCLES+1 edges after the acknowledging edge. The bench time-stamps every acknowledge by edge number and every new request at the falling edge. From these stamps it checks the exact gap, not a lower bound. `error` is due in the first falling edge after the failing acknowledge, and the bench checks a gap of zero there. The flags clear in the falling edge right after `start` is sampled. The bridge model in the bench logs accesses only when they are acknowledged. This makes the random acknowledge latency and the random count of zero-status polls invisible to the order checks.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef logic [7:0] byte_t;

  // bridge register offsets (decoded by the bridge)
  localparam byte_t BR_OP    = 8'h00;
  localparam byte_t BR_STAT  = 8'h01;
  localparam byte_t BR_EN    = 8'h02;
  localparam byte_t BR_SADDR = 8'h03;
  localparam byte_t BR_TXIDX = 8'h04;
  localparam byte_t BR_TXVAL = 8'h05;
  localparam byte_t BR_RXIDX = 8'h08;
  localparam byte_t BR_RXVAL = 8'h09;

  localparam byte_t OPC_WRITE = 8'h05;
  localparam byte_t OPC_READ  = 8'h70;
  localparam byte_t STS_WR_OK = 8'h04;
  localparam byte_t STS_RD_OK = 8'h01;

  localparam byte_t EN_KEY   = 8'h1e;
  localparam byte_t SLAVE_ID = 8'h60;

  localparam byte_t SN_CTRL      = 8'h12;
  localparam byte_t SN_RESET_VAL = 8'h80;
  localparam byte_t SN_MFR_HI    = 8'h1c;
  localparam byte_t SN_MFR_LO    = 8'h1d;
  localparam byte_t SN_PROD_HI   = 8'h0a;
  localparam byte_t SN_PROD_LO   = 8'h0b;
  localparam byte_t MFR_HI_EXP   = 8'h7f;
  localparam byte_t MFR_LO_EXP   = 8'ha2;
  localparam byte_t TBL_END      = 8'hff;

  typedef enum logic [1:0] {
    CMD_BRIDGE = 2'd0,
    CMD_SWRITE = 2'd1,
    CMD_SREAD  = 2'd2
  } cmd_kind_e;

  // init table entry {register, value}; index len and above is the terminator
  function automatic logic [15:0] tbl_entry(int unsigned i, int unsigned len);
    logic [7:0] ib;
    ib = 8'(i);
    if (i >= len)      return {TBL_END, TBL_END};
    else if (i == 2)   return {8'hff, 8'h11};
    else               return {8'h30 + ib, 8'ha0 ^ ib};
  endfunction

endpackage

// File: rtl/sbs_rst_sync.sv
module sbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sbs_rom.sv
module sbs_rom
  import sbs_pkg::*;
#(
  parameter int unsigned LEN = 6,
  parameter int unsigned IW  = 3
) (
  input  logic [IW-1:0] idx,
  output byte_t         reg_o,
  output byte_t         val_o
);
  localparam int unsigned DEPTH = 2 ** IW;

  logic [15:0] rom [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      assign rom[g] = tbl_entry(g, LEN);
    end
  endgenerate

  always_comb begin
    {reg_o, val_o} = rom[idx];
  end
endmodule

// File: rtl/sbs_delay.sv
module sbs_delay #(
  parameter int unsigned CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = run && (cnt_q == LAST);

  always_comb begin
    cnt_en = run || (cnt_q != '0);
    if (!run)         cnt_d = '0;
    else if (expired) cnt_d = cnt_q;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sbs_access.sv
module sbs_access
  import sbs_pkg::*;
#(
  parameter int unsigned MAX_POLLS = 50
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_valid,
  input  cmd_kind_e cmd_kind,
  input  byte_t     cmd_addr,
  input  byte_t     cmd_data,
  output logic      cmd_done,
  output logic      cmd_err,
  output byte_t     cmd_rdata,
  output logic      bus_req,
  output logic      bus_we,
  output byte_t     bus_addr,
  output byte_t     bus_wdata,
  input  logic      bus_ack,
  input  byte_t     bus_rdata
);
  localparam int unsigned PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] POLL_LIMIT = PW'(MAX_POLLS);

  typedef enum logic [2:0] {
    A_IDLE, A_RAW, A_IDX, A_VAL, A_OP, A_POLL, A_FETCH
  } ast_e;

  ast_e          st_q, st_d;
  cmd_kind_e     kind_q;
  byte_t         arg_a_q, arg_b_q;
  logic [PW-1:0] polls_q, polls_d, polls_inc;
  logic          load_en, polls_en, is_read;
  byte_t         exp_code;

  assign is_read   = (kind_q == CMD_SREAD);
  assign exp_code  = is_read ? STS_RD_OK : STS_WR_OK;
  assign polls_inc = polls_q + 1'b1;
  assign cmd_rdata = bus_rdata;

  // bus drive, decoded from the step being performed
  always_comb begin
    bus_req   = (st_q != A_IDLE);
    bus_we    = 1'b1;
    bus_addr  = BR_OP;
    bus_wdata = 8'h00;
    unique case (st_q)
      A_RAW:   begin bus_addr = arg_a_q; bus_wdata = arg_b_q; end
      A_IDX:   begin bus_addr = is_read ? BR_RXIDX : BR_TXIDX; bus_wdata = arg_a_q; end
      A_VAL:   begin bus_addr = BR_TXVAL; bus_wdata = arg_b_q; end
      A_OP:    begin bus_addr = BR_OP; bus_wdata = is_read ? OPC_READ : OPC_WRITE; end
      A_POLL:  begin bus_we = 1'b0; bus_addr = BR_STAT; end
      A_FETCH: begin bus_we = 1'b0; bus_addr = BR_RXVAL; end
      default: ;
    endcase
  end

  // next-state
  always_comb begin
    st_d     = st_q;
    polls_d  = polls_q;
    polls_en = 1'b0;
    load_en  = 1'b0;
    cmd_done = 1'b0;
    cmd_err  = 1'b0;
    unique case (st_q)
      A_IDLE: if (cmd_valid) begin
        load_en = 1'b1;
        st_d    = (cmd_kind == CMD_BRIDGE) ? A_RAW : A_IDX;
      end
      A_RAW: if (bus_ack) begin
        st_d     = A_IDLE;
        cmd_done = 1'b1;
      end
      A_IDX: if (bus_ack) st_d = is_read ? A_OP : A_VAL;
      A_VAL: if (bus_ack) st_d = A_OP;
      A_OP: if (bus_ack) begin
        st_d     = A_POLL;
        polls_d  = '0;
        polls_en = 1'b1;
      end
      A_POLL: if (bus_ack) begin
        polls_d  = polls_inc;
        polls_en = 1'b1;
        if ((bus_rdata == 8'h00) && (polls_inc < POLL_LIMIT)) begin
          st_d = A_POLL;
        end else if (bus_rdata == exp_code) begin
          if (is_read) begin
            st_d = A_FETCH;
          end else begin
            st_d     = A_IDLE;
            cmd_done = 1'b1;
          end
        end else begin
          st_d     = A_IDLE;
          cmd_done = 1'b1;
          cmd_err  = 1'b1;
        end
      end
      A_FETCH: if (bus_ack) begin
        st_d     = A_IDLE;
        cmd_done = 1'b1;
      end
      default: st_d = A_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= A_IDLE;
      polls_q <= '0;
      kind_q  <= CMD_BRIDGE;
      arg_a_q <= 8'h00;
      arg_b_q <= 8'h00;
    end else begin
      st_q <= st_d;
      if (polls_en) polls_q <= polls_d;
      if (load_en) begin
        kind_q  <= cmd_kind;
        arg_a_q <= cmd_addr;
        arg_b_q <= cmd_data;
      end
    end
  end
endmodule

// File: rtl/sensor_bringup_seq.sv
module sensor_bringup_seq
  import sbs_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES = 500000,
  parameter int unsigned MAX_POLLS    = 50,
  parameter int unsigned TABLE_LEN    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        bus_req,
  output logic        bus_we,
  output logic [7:0]  bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic        bus_ack,
  input  logic [7:0]  bus_rdata,
  output logic        done,
  output logic        error,
  output logic [15:0] product_id
);
  localparam int unsigned IW = $clog2(TABLE_LEN + 2);

  typedef enum logic [3:0] {
    S_IDLE, S_EN, S_SADDR, S_RST, S_WAIT1, S_MFRH, S_MFRL,
    S_PIDH, S_PIDL, S_TBL, S_WAIT2, S_DONE, S_ERR
  } sst_e;

  logic          rst_sync_n;
  sst_e          st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  byte_t         mfr_hi_q;
  logic [15:0]   pid_q, pid_d;
  logic          idx_en, mfr_en, pid_en;

  logic          cmd_valid, cmd_done, cmd_err;
  cmd_kind_e     cmd_kind;
  byte_t         cmd_addr, cmd_data, cmd_rdata;
  logic          dly_run, dly_expired;
  byte_t         tbl_reg, tbl_val;
  logic          tbl_term, start_ok;

  sbs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sbs_rom #(.LEN(TABLE_LEN), .IW(IW)) u_rom (
    .idx   (idx_q),
    .reg_o (tbl_reg),
    .val_o (tbl_val)
  );

  sbs_delay #(.CYCLES(DELAY_CYCLES)) u_dly (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (dly_run),
    .expired (dly_expired)
  );

  sbs_access #(.MAX_POLLS(MAX_POLLS)) u_acc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_done  (cmd_done),
    .cmd_err   (cmd_err),
    .cmd_rdata (cmd_rdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata)
  );

  assign tbl_term   = (tbl_reg == TBL_END) && (tbl_val == TBL_END);
  assign start_ok   = start && ((st_q == S_IDLE) || (st_q == S_DONE) || (st_q == S_ERR));
  assign done       = (st_q == S_DONE);
  assign error      = (st_q == S_ERR);
  assign product_id = pid_q;

  // next-state
  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    idx_en    = 1'b0;
    mfr_en    = 1'b0;
    pid_d     = pid_q;
    pid_en    = 1'b0;
    cmd_valid = 1'b0;
    cmd_kind  = CMD_BRIDGE;
    cmd_addr  = 8'h00;
    cmd_data  = 8'h00;
    dly_run   = 1'b0;
    unique case (st_q)
      S_IDLE, S_DONE, S_ERR: if (start_ok) begin
        st_d   = S_EN;
        idx_d  = '0;
        idx_en = 1'b1;
        pid_d  = 16'h0000;
        pid_en = 1'b1;
      end
      S_EN: begin
        cmd_valid = 1'b1;
        cmd_addr  = BR_EN;
        cmd_data  = EN_KEY;
        if (cmd_done) st_d = S_SADDR;
      end
      S_SADDR: begin
        cmd_valid = 1'b1;
        cmd_addr  = BR_SADDR;
        cmd_data  = SLAVE_ID;
        if (cmd_done) st_d = S_RST;
      end
      S_RST: begin
        cmd_valid = 1'b1;
        cmd_kind  = CMD_SWRITE;
        cmd_addr  = SN_CTRL;
        cmd_data  = SN_RESET_VAL;
        if (cmd_done) st_d = cmd_err ? S_ERR : S_WAIT1;
      end
      S_WAIT1: begin
        dly_run = 1'b1;
        if (dly_expired) st_d = S_MFRH;
      end
      S_MFRH: begin
        cmd_valid = 1'b1;
        cmd_kind  = CMD_SREAD;
        cmd_addr  = SN_MFR_HI;
        if (cmd_done) begin
          mfr_en = !cmd_err;
          st_d   = cmd_err ? S_ERR : S_MFRL;
        end
      end
      S_MFRL: begin
        cmd_valid = 1'b1;
        cmd_kind  = CMD_SREAD;
        cmd_addr  = SN_MFR_LO;
        if (cmd_done) begin
          if (cmd_err || (mfr_hi_q != MFR_HI_EXP) || (cmd_rdata != MFR_LO_EXP))
            st_d = S_ERR;
          else
            st_d = S_PIDH;
        end
      end
      S_PIDH: begin
        cmd_valid = 1'b1;
        cmd_kind  = CMD_SREAD;
        cmd_addr  = SN_PROD_HI;
        if (cmd_done) begin
          pid_d  = {cmd_rdata, pid_q[7:0]};
          pid_en = !cmd_err;
          st_d   = cmd_err ? S_ERR : S_PIDL;
        end
      end
      S_PIDL: begin
        cmd_valid = 1'b1;
        cmd_kind  = CMD_SREAD;
        cmd_addr  = SN_PROD_LO;
        if (cmd_done) begin
          pid_d  = {pid_q[15:8], cmd_rdata};
          pid_en = !cmd_err;
          st_d   = cmd_err ? S_ERR : S_TBL;
        end
      end
      S_TBL: begin
        if (tbl_term) begin
          st_d = S_WAIT2;
        end else begin
          cmd_valid = 1'b1;
          cmd_kind  = CMD_SWRITE;
          cmd_addr  = tbl_reg;
          cmd_data  = tbl_val;
          if (cmd_done) begin
            if (cmd_err) begin
              st_d = S_ERR;
            end else begin
              idx_d  = idx_q + 1'b1;
              idx_en = 1'b1;
            end
          end
        end
      end
      S_WAIT2: begin
        dly_run = 1'b1;
        if (dly_expired) st_d = S_DONE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q     <= S_IDLE;
      idx_q    <= '0;
      mfr_hi_q <= 8'h00;
      pid_q    <= 16'h0000;
    end else begin
      st_q <= st_d;
      if (idx_en) idx_q    <= idx_d;
      if (mfr_en) mfr_hi_q <= cmd_rdata;
      if (pid_en) pid_q    <= pid_d;
    end
  end
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int unsigned MAX_POLLS = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       bus_req,
  input logic       bus_we,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_ack,
  input logic       done,
  input logic       error
);
  localparam int unsigned SW = $clog2(MAX_POLLS + 2);

  logic [SW-1:0] stat_run_q;

  // run length of back-to-back acknowledged status reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_run_q <= '0;
    end else if (bus_req && bus_ack) begin
      if (!bus_we && (bus_addr == 8'h01)) begin
        if (stat_run_q != {SW{1'b1}}) stat_run_q <= stat_run_q + 1'b1;
      end else begin
        stat_run_q <= '0;
      end
    end
  end

  // R5: never more status reads per access than the limit
  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(stat_run_q) <= MAX_POLLS);

  // R5: aborted sequencer makes no request
  a_r5_quiet_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !bus_req);

  // R10: a finished sequencer makes no request
  a_r10_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  // R11: flags hold without a start
  a_r11_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R12: request and its fields held until acknowledged
  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)
                               && $stable(bus_wdata)));
endmodule

bind sensor_bringup_seq sbs_checker #(.MAX_POLLS(MAX_POLLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack),
  .done      (done),
  .error     (error)
);

// File: tb/sim_sensor_bringup_seq.sv
`timescale 1ns/1ps
module sim_sensor_bringup_seq;
  localparam int D  = 40;
  localparam int MP = 50;
  localparam int TL = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        bus_req, bus_we;
  logic [7:0]  bus_addr, bus_wdata;
  logic        bus_ack = 1'b0;
  logic [7:0]  bus_rdata = 8'h00;
  logic        done, error;
  logic [15:0] product_id;

  sensor_bringup_seq #(.DELAY_CYCLES(D), .MAX_POLLS(MP), .TABLE_LEN(TL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .done(done), .error(error), .product_id(product_id)
  );

  always #10 clk = ~clk;   // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errs = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- bridge + sensor model ----------------
  logic [7:0] sens [256];
  logic [7:0] tx_idx, tx_val, rx_idx, fin_code;
  bit         in_txn, to_mode;
  int         lat, zeros_left, op_count, timeout_op, badcode_op, stat_reads;
  int         prev_ack_cyc, txn_gap;
  bit         log_we [128];
  logic [7:0] log_addr [128];
  logic [7:0] log_data [128];
  int         log_gap [128];
  int         log_n;

  task automatic logit(input bit we, input logic [7:0] a, input logic [7:0] d);
    if (log_n < 128) begin
      log_we[log_n] = we; log_addr[log_n] = a; log_data[log_n] = d; log_gap[log_n] = txn_gap;
      log_n++;
    end
  endtask

  task automatic serve();
    bus_ack = 1'b1;
    prev_ack_cyc = cyc + 1;
    bus_rdata = 8'h00;
    if (bus_we) begin
      case (bus_addr)
        8'h04: tx_idx = bus_wdata;
        8'h05: tx_val = bus_wdata;
        8'h08: rx_idx = bus_wdata;
        8'h00: begin
          op_count++;
          zeros_left = $urandom % 4;
          to_mode = (op_count == timeout_op);
          if (bus_wdata == 8'h05) begin sens[tx_idx] = tx_val; fin_code = 8'h04; end
          else fin_code = 8'h01;
          if (op_count == badcode_op) fin_code = 8'h02;
        end
        default: ;
      endcase
      logit(1'b1, bus_addr, bus_wdata);
    end else if (bus_addr == 8'h01) begin
      stat_reads++;
      if (to_mode || zeros_left > 0) begin
        bus_rdata = 8'h00;
        if (zeros_left > 0) zeros_left--;
      end else bus_rdata = fin_code;
    end else begin
      if (bus_addr == 8'h09) bus_rdata = sens[rx_idx];
      logit(1'b0, bus_addr, bus_rdata);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0; in_txn = 1'b0;
    end else begin
      if (bus_ack) begin bus_ack = 1'b0; in_txn = 1'b0; end
      if (bus_req && !in_txn) begin
        in_txn = 1'b1; lat = $urandom % 3; txn_gap = cyc - prev_ack_cyc;
      end
      if (in_txn) begin
        if (lat == 0) serve(); else lat--;
      end
    end
  end

  // ---------------- expected sequence ----------------
  bit         exp_we [128];
  logic [7:0] exp_addr [128];
  logic [7:0] exp_data [128];
  int         exp_n;

  function automatic logic [7:0] t_reg(int i);
    return (i == 2) ? 8'hff : 8'(8'h30 + i);
  endfunction
  function automatic logic [7:0] t_val(int i);
    return (i == 2) ? 8'h11 : (8'ha0 ^ 8'(i));
  endfunction

  task automatic push(input bit we, input logic [7:0] a, input logic [7:0] d);
    exp_we[exp_n] = we; exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_n++;
  endtask
  task automatic e_swr(input logic [7:0] r, input logic [7:0] v);
    push(1, 8'h04, r); push(1, 8'h05, v); push(1, 8'h00, 8'h05);
  endtask

  // ops: 1 reset write, 2..5 id reads, 6.. table writes
  task automatic build_exp(input int last, input bit cut_fetch);
    logic [7:0] r;
    exp_n = 0;
    push(1, 8'h02, 8'h1e); push(1, 8'h03, 8'h60);
    for (int k = 1; k <= last; k++) begin
      if (k == 1) e_swr(8'h12, 8'h80);
      else if (k <= 5) begin
        r = (k == 2) ? 8'h1c : (k == 3) ? 8'h1d : (k == 4) ? 8'h0a : 8'h0b;
        push(1, 8'h08, r); push(1, 8'h00, 8'h70);
        if (!(cut_fetch && k == last)) push(0, 8'h09, sens[r]);
      end else e_swr(t_reg(k - 6), t_val(k - 6));
    end
  endtask

  task automatic cmp_log(input string tag);
    int bad;
    bad = -1;
    chk(log_n == exp_n, {tag, " access count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && (log_we[i] != exp_we[i] || log_addr[i] != exp_addr[i] || log_data[i] != exp_data[i]))
        bad = i;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, {tag, " access {we,addr,data}"},
             {log_we[bad], log_addr[bad], log_data[bad]}, {exp_we[bad], exp_addr[bad], exp_data[bad]});
  endtask

  task automatic init_sensor(input logic [15:0] pid, input logic [7:0] mlo);
    for (int i = 0; i < 256; i++) sens[i] = 8'h00;
    sens[8'h1c] = 8'h7f; sens[8'h1d] = mlo;
    sens[8'h0a] = pid[15:8]; sens[8'h0b] = pid[7:0];
    timeout_op = 0; badcode_op = 0;
  endtask

  bit flag_err_at_start, flag_done_at_start;
  int end_cyc;

  task automatic run_once(input bit poke_busy);
    int n;
    op_count = 0; stat_reads = 0; log_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    flag_err_at_start = error; flag_done_at_start = done;
    if (poke_busy) begin
      repeat (15) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!(done || error) && n < 20000) begin @(negedge clk); n++; end
    end_cyc = cyc;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int seed;
    logic [15:0] pid;
    int bc;
    seed = $urandom(32'd2718);
    prev_ack_cyc = 0; txn_gap = 0; log_n = 0;
    init_sensor(16'h9652, 8'ha2);

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(error == 1'b0, "R1 error after reset", error, 0);
    chk(bus_req == 1'b0, "R1 bus_req after reset", bus_req, 0);
    chk(product_id == 16'h0, "R1 product_id after reset", product_id, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // nominal directed run: R2 R3 R4 R6 R8 R9 R10
    run_once(1'b0);
    build_exp(5 + TL, 1'b0);
    chk(log_addr[0] == 8'h02 && log_data[0] == 8'h1e, "R2 first bridge write",
        {log_addr[0], log_data[0]}, 16'h021e);
    chk(log_addr[1] == 8'h03 && log_data[1] == 8'h60, "R2 second bridge write",
        {log_addr[1], log_data[1]}, 16'h0360);
    cmp_log("R3 R4 R9 nominal order");
    chk(log_gap[5] == D + 1, "R6 wait after reset write", log_gap[5], D + 1);
    chk(product_id == 16'h9652, "R8 product id", product_id, 16'h9652);
    chk(done == 1'b1 && error == 1'b0, "R10 done flag", {done, error}, 2'b10);
    chk(end_cyc - prev_ack_cyc == D + 1, "R10 done timing", end_cyc - prev_ack_cyc, D + 1);
    repeat (20) @(negedge clk);
    chk(done == 1'b1 && bus_req == 1'b0, "R11 done held", {done, bus_req}, 2'b10);

    // start during a run is ignored: R11
    init_sensor(16'h1234, 8'ha2);
    run_once(1'b1);
    chk(flag_done_at_start == 1'b0, "R11 done cleared by start", flag_done_at_start, 0);
    build_exp(5 + TL, 1'b0);
    cmp_log("R11 busy start ignored");
    chk(product_id == 16'h1234, "R8 product id second run", product_id, 16'h1234);

    // bad maker code: R7
    init_sensor(16'h5555, 8'ha3);
    run_once(1'b0);
    build_exp(3, 1'b0);
    chk(error == 1'b1 && done == 1'b0, "R7 error on id mismatch", {done, error}, 2'b01);
    cmp_log("R7 no product read");
    repeat (30) @(negedge clk);
    chk(error == 1'b1 && log_n == exp_n, "R11 error held and quiet", log_n, exp_n);

    // restart from error clears error: R11
    init_sensor(16'h0f0e, 8'ha2);
    run_once(1'b0);
    chk(flag_err_at_start == 1'b0, "R11 error cleared by start", flag_err_at_start, 0);
    chk(done == 1'b1 && product_id == 16'h0f0e, "R11 rerun completes", product_id, 16'h0f0e);

    // status stays zero: R5 timeout on reset write
    init_sensor(16'h9652, 8'ha2);
    timeout_op = 1;
    run_once(1'b0);
    chk(error == 1'b1, "R5 timeout error", error, 1);
    chk(stat_reads == MP, "R5 poll count", stat_reads, MP);
    chk(end_cyc - prev_ack_cyc == 0, "R5 error timing", end_cyc - prev_ack_cyc, 0);
    build_exp(1, 1'b0);
    cmp_log("R5 stop after timeout");

    // wrong completion code on a read: R5 R4
    init_sensor(16'h9652, 8'ha2);
    badcode_op = 4;
    run_once(1'b0);
    build_exp(4, 1'b1);
    chk(error == 1'b1, "R5 bad code error", error, 1);
    cmp_log("R4 R5 stop before fetch");

    // random runs
    for (int r = 0; r < 6; r++) begin
      pid = 16'($urandom);
      init_sensor(pid, 8'ha2);
      bc = (r % 2 == 1) ? 6 + int'($urandom % TL) : 0;
      badcode_op = bc;
      run_once(1'b0);
      if (bc == 0) begin
        build_exp(5 + TL, 1'b0);
        chk(done == 1'b1 && product_id == pid, "R8 random product id", product_id, pid);
        cmp_log("R9 random nominal");
      end else begin
        build_exp(bc, 1'b0);
        chk(error == 1'b1 && done == 1'b0, "R5 random table fault", {done, error}, 2'b01);
        cmp_log("R9 random table fault");
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule